// File: doc/BRIEF.md
# Bidirectional Word-Length Transposing Store

This block is a bit-matrix store of `ROWS` x `COLS` bits (32 x 1024 by default) that can be reached along either axis. A long-word access moves one complete row of `COLS` bits. A short-word access moves one column, which is a single bit taken from every row at the same column index. Both views share the same storage, so a row written as a long word can be read back one column at a time, and the reverse also works. This makes the block a word-length converter between a very wide datapath and a narrow one.

Every access runs a fixed two-phase cycle. In the sense phase the selected word is copied into the buffer register for its submode and cleared in the store. In the restore phase the buffer is written back into the same word. A read therefore restores what it sensed. A write loads its buffer from the input bus when the request is accepted and discards the sensed value, so the addressed word is replaced. Requests arrive on a single valid/ready port. A one-cycle `done` pulse marks the end of each cycle, and read data is presented on the bus that matches the submode.

Top module: `xposeMem`

## Requirements
- R1: After reset every stored bit is 0, `reqReady` is 1, and `done` and `err` are 0.
- R2: A long write (`reqLong`=1, `reqWrite`=1) to row `reqAddr` replaces that whole row with `wrLong`. A later long read of the row returns the same value on `rdLong`, and no other row changes.
- R3: A short write (`reqLong`=0, `reqWrite`=1) to column `reqAddr` sets bit `c` of every row `r` to `wrShort[r]`. A later short read of that column returns the same value on `rdShort`, and no other column changes.
- R4: The two views are transposes of each other. Bit `r` of a short read of column `c` equals bit `c` of a long read of row `r`, whichever submode wrote the data.
- R5: A read cycle leaves the store unchanged, so reading the same word twice returns the same data both times.
- R6: `done` is high for exactly one cycle. A request accepted at clock edge N raises `done` after edge N+2. Read data on `rdLong` or `rdShort` is valid while `done` is high.
- R7: `reqReady` is low during the two clock cycles after an accepted request. A request presented in that time is not taken.
- R8: A long request whose `reqAddr` is at or above `ROWS` is not accepted. It raises `err` for one cycle after the edge where it was presented, `reqReady` stays high, no `done` follows, and the store is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle, request can be taken |
| reqLong | input | 1 | 1 = long-word submode (row), 0 = short-word submode (column) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW (10) | Row index (long) or column index (short) |
| wrLong | input | COLS (1024) | Write data for long writes |
| wrShort | input | ROWS (32) | Write data for short writes, bit r goes to row r |
| rdLong | output | COLS (1024) | Long read data, valid with done |
| rdShort | output | ROWS (32) | Short read data, valid with done |
| done | output | 1 | One-cycle end-of-cycle pulse |
| err | output | 1 | One-cycle pulse for a rejected out-of-range long address |

## Verification
The properties assume that a requester never counts on a request being taken while `reqReady` is low. They also assume that the mode, operation and address are steady during the cycle in which the request is presented. The bench drives every request on the falling edge, holds it across exactly one rising edge, and drops `reqValid` before the next edge. Out-of-range long addresses are presented only while the block is idle, so that the error pulse and the absence of any cycle can be observed cleanly.

// File: rtl/xposeMem_pkg.sv
package xposeMem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SENSE   = 2'd1,
    PH_RESTORE = 2'd2
  } phase_e;

  typedef struct packed {
    logic load;
    logic sense;
    logic restore;
    logic useLong;
    logic doWrite;
  } strobes_t;

endpackage

// File: rtl/xposeCtrl.sv
module xposeCtrl
  import xposeMem_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 1024,
  parameter int AW   = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqLong,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  output logic          done,
  output logic          err,
  output strobes_t      stb
);

  phase_e phaseQ;
  logic   longQ;
  logic   writeQ;
  logic   badAddr;
  logic   accept;
  logic   reject;

  always_comb begin
    if (reqLong) badAddr = (int'(reqAddr) >= ROWS);
    else         badAddr = (int'(reqAddr) >= COLS);
  end

  assign reqReady = (phaseQ == PH_IDLE);
  assign accept   = reqValid && reqReady && !badAddr;
  assign reject   = reqValid && reqReady && badAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      longQ  <= 1'b0;
      writeQ <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= (phaseQ == PH_RESTORE);
      err  <= reject;
      case (phaseQ)
        PH_IDLE: begin
          if (accept) begin
            phaseQ <= PH_SENSE;
            longQ  <= reqLong;
            writeQ <= reqWrite;
          end
        end
        PH_SENSE:   phaseQ <= PH_RESTORE;
        PH_RESTORE: phaseQ <= PH_IDLE;
        default:    phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load    = accept;
    stb.sense   = (phaseQ == PH_SENSE);
    stb.restore = (phaseQ == PH_RESTORE);
    stb.useLong = accept ? reqLong  : longQ;
    stb.doWrite = accept ? reqWrite : writeQ;
  end

endmodule

// File: rtl/xposeDatapath.sv
module xposeDatapath
  import xposeMem_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 1024,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [AW-1:0]   reqAddr,
  input  logic [COLS-1:0] wrLong,
  input  logic [ROWS-1:0] wrShort,
  output logic [COLS-1:0] rdLong,
  output logic [ROWS-1:0] rdShort
);

  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [RAW-1:0]  rowSelQ;
  logic [CAW-1:0]  colSelQ;
  logic [COLS-1:0] longBuf;
  logic [ROWS-1:0] shortBuf;
  logic [COLS-1:0] rowView [ROWS];
  logic [ROWS-1:0] colSense;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowSelQ <= '0;
      colSelQ <= '0;
    end else if (stb.load) begin
      rowSelQ <= reqAddr[RAW-1:0];
      colSelQ <= reqAddr[CAW-1:0];
    end
  end

  // Buffer registers: loaded from the input bus for writes, from the sensed word for reads
  always_ff @(posedge clk) begin
    if (!rstN) begin
      longBuf  <= '0;
      shortBuf <= '0;
    end else if (stb.load && stb.doWrite) begin
      if (stb.useLong) longBuf  <= wrLong;
      else             shortBuf <= wrShort;
    end else if (stb.sense && !stb.doWrite) begin
      if (stb.useLong) longBuf  <= rowView[rowSelQ];
      else             shortBuf <= colSense;
    end
  end

  // One storage row per generate iteration; each is cut by row or by column
  for (genvar gr = 0; gr < ROWS; gr++) begin : gRow
    logic [COLS-1:0] rowQ;
    logic            rowHit;

    assign rowHit      = (int'(rowSelQ) == gr);
    assign rowView[gr] = rowQ;
    assign colSense[gr] = rowQ[colSelQ];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rowQ <= '0;
      end else if (stb.sense) begin
        if (stb.useLong) begin
          if (rowHit) rowQ <= '0;
        end else begin
          rowQ[colSelQ] <= 1'b0;
        end
      end else if (stb.restore) begin
        if (stb.useLong) begin
          if (rowHit) rowQ <= longBuf;
        end else begin
          rowQ[colSelQ] <= shortBuf[gr];
        end
      end
    end
  end

  assign rdLong  = longBuf;
  assign rdShort = shortBuf;

endmodule

// File: rtl/xposeMem.sv
module xposeMem
  import xposeMem_pkg::*;
#(
  parameter int ROWS = 32,
  parameter int COLS = 1024,
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW  = (RAW > CAW) ? RAW : CAW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqLong,
  input  logic            reqWrite,
  input  logic [AW-1:0]   reqAddr,
  input  logic [COLS-1:0] wrLong,
  input  logic [ROWS-1:0] wrShort,
  output logic [COLS-1:0] rdLong,
  output logic [ROWS-1:0] rdShort,
  output logic            done,
  output logic            err
);

  strobes_t stb;

  xposeCtrl #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLong  (reqLong),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqReady (reqReady),
    .done     (done),
    .err      (err),
    .stb      (stb)
  );

  xposeDatapath #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .wrLong  (wrLong),
    .wrShort (wrShort),
    .rdLong  (rdLong),
    .rdShort (rdShort)
  );

endmodule

// File: rtl/xposeMem_chk.sv
module xposeMem_chk #(
  parameter int ROWS = 32,
  parameter int AW   = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          reqLong,
  input logic [AW-1:0] reqAddr,
  input logic          done,
  input logic          err
);

  logic badLong;
  assign badLong = reqLong && (int'(reqAddr) >= ROWS);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !badLong |=> !reqReady ##1 !reqReady);              // R7

  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !badLong |=> !done ##1 !done ##1 done);             // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                           // R6

  AST_BAD_ADDR_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && badLong |=> err && reqReady);                       // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(reqValid && reqReady && badLong));                            // R8

  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));                                                           // R8

endmodule

bind xposeMem xposeMem_chk #(.ROWS(ROWS), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqLong  (reqLong),
  .reqAddr  (reqAddr),
  .done     (done),
  .err      (err)
);

// File: tb/xposeMem_tb.sv
module xposeMem_tb;

  localparam int ROWS = 32;
  localparam int COLS = 1024;
  localparam int AW   = 10;

  typedef struct {
    bit              isLong;
    bit              isRead;
    logic [COLS-1:0] expLong;
    logic [ROWS-1:0] expShort;
    string           tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic            reqLong = 1'b0;
  logic            reqWrite = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [COLS-1:0] wrLong = '0;
  logic [ROWS-1:0] wrShort = '0;
  logic [COLS-1:0] rdLong;
  logic [ROWS-1:0] rdShort;
  logic            done;
  logic            err;

  int checks = 0;
  int fails  = 0;
  logic [COLS-1:0] model [ROWS];
  item_t sbQ [$];

  always #10 clk = ~clk;

  xposeMem #(.ROWS(ROWS), .COLS(COLS)) u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] colOf(input int c);
    logic [ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++) v[r] = model[r][c];
    return v;
  endfunction

  // Driver: presents one request, updates the model, queues the expectation
  task automatic doReq(input bit isLong, input bit isWrite, input int addr,
                       input logic [COLS-1:0] dl, input logic [ROWS-1:0] ds,
                       input string tag);
    item_t it;
    @(negedge clk);
    reqValid = 1'b1; reqLong = isLong; reqWrite = isWrite;
    reqAddr = AW'(addr); wrLong = dl; wrShort = ds;
    it.isLong = isLong; it.isRead = !isWrite; it.tag = tag;
    if (isWrite) begin
      if (isLong) model[addr] = dl;
      else for (int r = 0; r < ROWS; r++) model[r][addr] = ds[r];
    end
    it.expLong  = isLong ? model[addr] : '0;
    it.expShort = isLong ? '0 : colOf(addr);
    sbQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R7", "ready after accept", COLS'(reqReady), '0);
    // present a second request while busy: it must not start a cycle
    reqValid = 1'b1; reqWrite = 1'b1; wrLong = ~dl; wrShort = ~ds;
    @(negedge clk);
    check(reqReady == 1'b0, "R7", "ready two cycles after accept", COLS'(reqReady), '0);
    check(done == 1'b0, "R6", "done early", COLS'(done), '0);
    reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R6", "done after two phases", COLS'(done), 1);
    check(reqReady == 1'b1, "R7", "ready back", COLS'(reqReady), 1);
  endtask

  // Monitor: pops an expected item on each done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      item_t it;
      if (sbQ.size() == 0) begin
        check(1'b0, "R6", "unexpected done", COLS'(done), '0);
      end else begin
        it = sbQ.pop_front();
        if (it.isRead && it.isLong)
          check(rdLong === it.expLong, it.tag, "long read", rdLong, it.expLong);
        else if (it.isRead)
          check(rdShort === it.expShort, it.tag, "short read",
                COLS'(rdShort), COLS'(it.expShort));
      end
    end
  end

  task automatic badReq(input int addr);
    @(negedge clk);
    reqValid = 1'b1; reqLong = 1'b1; reqWrite = 1'b1;
    reqAddr = AW'(addr); wrLong = '1;
    @(negedge clk);
    reqValid = 1'b0;
    check(err == 1'b1, "R8", "err pulse", COLS'(err), 1);
    check(reqReady == 1'b1, "R8", "ready stays", COLS'(reqReady), 1);
    @(negedge clk);
    check(err == 1'b0, "R8", "err one cycle", COLS'(err), '0);
    check(done == 1'b0, "R8", "no done", COLS'(done), '0);
  endtask

  function automatic logic [COLS-1:0] pat(input int seed);
    logic [COLS-1:0] v;
    for (int w = 0; w < COLS / 32; w++)
      v[w*32 +: 32] = 32'h9E37_79B9 * (seed + 1) ^ (w * 32'h0101_0007);
    return v;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "ready", COLS'(reqReady), 1);
    check(done == 1'b0 && err == 1'b0, "R1", "done/err", COLS'({done, err}), '0);
    doReq(1, 0, 0, '0, '0, "R1");
    doReq(0, 0, 517, '0, '0, "R1");

    // R2 long write/read, neighbours untouched
    doReq(1, 1, 3, pat(3), '0, "R2");
    doReq(1, 0, 3, '0, '0, "R2");
    doReq(1, 0, 4, '0, '0, "R2");
    doReq(1, 1, 31, pat(31), '0, "R2");
    doReq(1, 0, 31, '0, '0, "R2");

    // R4 transpose view of long data
    doReq(0, 0, 5, '0, '0, "R4");
    doReq(0, 0, 1023, '0, '0, "R4");

    // R3 short write/read, other columns untouched
    doReq(0, 1, 7, '0, 32'hDEAD_BEEF, "R3");
    doReq(0, 0, 7, '0, '0, "R3");
    doReq(0, 0, 8, '0, '0, "R3");
    doReq(0, 1, 0, '0, 32'h8000_0001, "R3");
    doReq(0, 0, 0, '0, '0, "R3");

    // R4 long view of short data
    doReq(1, 0, 3, '0, '0, "R4");
    doReq(1, 0, 0, '0, '0, "R4");
    doReq(1, 0, 31, '0, '0, "R4");

    // R5 repeated reads are stable
    doReq(1, 0, 3, '0, '0, "R5");
    doReq(0, 0, 7, '0, '0, "R5");
    doReq(0, 0, 7, '0, '0, "R5");

    // R8 out-of-range long address: no effect (low bits alias row 8 and row 0)
    badReq(40);
    badReq(32);
    doReq(1, 0, 8, '0, '0, "R8");
    doReq(1, 0, 0, '0, '0, "R8");

    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R6", "all cycles completed", COLS'(sbQ.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule